// File: doc/BRIEF.md
# Cascadable Multiply-Accumulate Arithmetic Slice

This block is a pipelined arithmetic slice. A signed 18x18 multiplier produces a 36-bit product. The product is sign-extended and fed into a three-input 48-bit adder/subtracter. A 7-bit mode word is sampled with the operands on every clock, so the slice can switch on any cycle between multiply, multiply-add, three-operand addition, accumulation and cascade arithmetic. No reconfiguration is needed.

Slices chain together in columns. The B operand can be taken from a neighbour's B cascade output and is passed on to the next slice. The 48-bit result leaves on the P port and on a cascade P output. A neighbour's cascade P value can enter the adder directly. It can also enter after an arithmetic shift right by 17, which aligns partial products when several slices build a wider multiply. Symmetric rounding uses two things together: a carry-in taken from the inverted sign of the product, and a constant supplied through C. The input, product and output register stages can each be removed by a parameter.

Top module: `mac_slice`

## Requirements
- R1: The product of a and b, both 18-bit two's complement, is exact to 36 bits and is sign-extended to 48 bits. With X select = 1 it enters the adder; for example, -131072 * -131072 gives 0x000400000000.
- R2: The mode word is {Z[6:4], Y[3:2], X[1:0]}.
  - X: 0 = zero, 1 = product, 2 = P feedback, 3 = zero.
  - Y: 1 = C, any other code = zero.
  - Z: 0 = zero, 1 = cascade P in, 2 = P feedback, 3 = C, 4 = cascade P in shifted right by 17, 5 = P feedback shifted right by 17, 6 and 7 = zero.
  - Selecting C on both Y and Z gives a three-operand sum.
- R3: With sub = 0 the result is Z + X + Y + cin. With sub = 1 it is Z - (X + Y + cin), wrapped to 48 bits.
- R4: With rnd_en = 0, cin is the carry_in input. With rnd_en = 1, cin is the inverse of the product's sign bit, so a product of zero gets cin = 1. Together with C = 2^(k-1) - 1, this makes the k low bits round half away from zero.
- R5: With PREG = 1, the feedback selections use the registered P. For example, Z = P with X = product adds the product once per cycle. With PREG = 0, feedback selections contribute zero.
- R6: Both shift selections are arithmetic shifts right by 17 and copy the sign bit into the vacated top bits. For example, cascade-in 0xFFFFFFF00000 shifted becomes -8.
- R7: b_sel = 1 takes B from bcin instead of b. bcout is the selected B after the input register stage.
- R8: pcout always carries the same value as p.
- R9: A result appears AREG + MREG + PREG rising edges after its operands. The mode word, sub, carry_in, rnd_en and C travel with a and b. Cascade P in is sampled at the adder stage, with no delay.
- R10: rst_data synchronously clears every data register (A, B, C, product, P) to zero, and it overrides ce_data.
- R11: With ce_data = 0, every data register holds its value, so a registered p does not change.
- R12: rst_ctrl synchronously clears the control registers; a cleared mode gives a result of zero. With ce_ctrl = 0, the control registers hold, so the old mode stays in force while the data keeps moving.
- R13: With rst_n low, all registers are cleared at once. Release takes effect two rising edges after rst_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_data | input | 1 | Clock enable for data registers |
| ce_ctrl | input | 1 | Clock enable for control registers |
| rst_data | input | 1 | Synchronous reset of data registers |
| rst_ctrl | input | 1 | Synchronous reset of control registers |
| a | input | 18 | Signed multiplier operand A |
| b | input | 18 | Signed multiplier operand B |
| bcin | input | 18 | B cascade input from the neighbouring slice |
| b_sel | input | 1 | 1 selects bcin as the B operand |
| c | input | 48 | Addend, third operand or rounding constant |
| opmode | input | 7 | Adder input selection {Z, Y, X} |
| sub | input | 1 | 1 selects subtraction |
| carry_in | input | 1 | Carry-in when rounding is off |
| rnd_en | input | 1 | 1 takes the carry-in from the inverted product sign |
| pcin | input | 48 | P cascade input from the neighbouring slice |
| p | output | 48 | Result |
| pcout | output | 48 | P cascade output |
| bcout | output | 18 | B cascade output |

## Verification
With the default settings, a result is due on the third rising edge after its operands. With only the input and output stages kept it is due on the second edge, and with no stages it is due within the same cycle. The bench feeds one vector table into all three configurations at once, applying a new vector on each falling edge. On that falling edge it compares each output against the vector issued three, two or zero edges earlier, according to the configuration. The directed tests cover feedback, enables, resets and cascade inputs. In these tests the inputs are held steady and each check waits long enough for the whole pipeline to settle. The cascade P input bypasses the operand stages, so it needs only the output register to have clocked.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;

  typedef enum logic [1:0] {
    XS_ZERO = 2'd0,
    XS_PROD = 2'd1,
    XS_PFB  = 2'd2,
    XS_NONE = 2'd3
  } x_sel_e;

  typedef enum logic [1:0] {
    YS_ZERO = 2'd0,
    YS_C    = 2'd1,
    YS_NA   = 2'd2,
    YS_NB   = 2'd3
  } y_sel_e;

  typedef enum logic [2:0] {
    ZS_ZERO    = 3'd0,
    ZS_PCIN    = 3'd1,
    ZS_PFB     = 3'd2,
    ZS_C       = 3'd3,
    ZS_PCIN_SH = 3'd4,
    ZS_PFB_SH  = 3'd5,
    ZS_NA      = 3'd6,
    ZS_NB      = 3'd7
  } z_sel_e;

  typedef struct packed {
    z_sel_e zsel;
    y_sel_e ysel;
    x_sel_e xsel;
    logic   sub;
    logic   cin;
    logic   rnd;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/mac_pipe.sv
module mac_pipe #(
  parameter int W  = 1,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN) begin : g_reg
      logic [W-1:0] q_r;
      logic [W-1:0] q_nxt;

      always_comb begin
        q_nxt = q_r;
        if (srst)    q_nxt = '0;
        else if (ce) q_nxt = d;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= q_nxt;
      end

      assign q = q_r;
    end else begin : g_wire
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/mac_mult.sv
module mac_mult
  import mac_slice_pkg::*;
#(
  parameter int AW   = 18,
  parameter int BW   = 18,
  parameter int PW   = 48,
  parameter bit AREG = 1'b1,
  parameter bit MREG = 1'b1,
  localparam int MW  = AW + BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_data,
  input  logic          ce_ctrl,
  input  logic          rst_data,
  input  logic          rst_ctrl,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic [PW-1:0] c,
  input  ctrl_t         ctrl,
  output logic [BW-1:0] b_q,
  output logic [MW-1:0] prod_m,
  output logic [PW-1:0] c_m,
  output ctrl_t         ctrl_m
);

  logic [AW-1:0]        a_q;
  logic [PW-1:0]        c_q;
  ctrl_t                ctrl_q;
  logic signed [MW-1:0] prod;

  mac_pipe #(.W(AW), .EN(AREG)) u_areg (
    .clk(clk), .rst_n(rst_n), .srst(rst_data), .ce(ce_data), .d(a), .q(a_q));
  mac_pipe #(.W(BW), .EN(AREG)) u_breg (
    .clk(clk), .rst_n(rst_n), .srst(rst_data), .ce(ce_data), .d(b), .q(b_q));
  mac_pipe #(.W(PW), .EN(AREG)) u_creg (
    .clk(clk), .rst_n(rst_n), .srst(rst_data), .ce(ce_data), .d(c), .q(c_q));
  mac_pipe #(.W(CTRL_W), .EN(AREG)) u_ctl1 (
    .clk(clk), .rst_n(rst_n), .srst(rst_ctrl), .ce(ce_ctrl), .d(ctrl), .q(ctrl_q));

  always_comb begin
    prod = $signed(a_q) * $signed(b_q);
  end

  mac_pipe #(.W(MW), .EN(MREG)) u_mreg (
    .clk(clk), .rst_n(rst_n), .srst(rst_data), .ce(ce_data), .d(prod), .q(prod_m));
  mac_pipe #(.W(PW), .EN(MREG)) u_creg2 (
    .clk(clk), .rst_n(rst_n), .srst(rst_data), .ce(ce_data), .d(c_q), .q(c_m));
  mac_pipe #(.W(CTRL_W), .EN(MREG)) u_ctl2 (
    .clk(clk), .rst_n(rst_n), .srst(rst_ctrl), .ce(ce_ctrl), .d(ctrl_q), .q(ctrl_m));

endmodule

// File: rtl/mac_alu.sv
module mac_alu
  import mac_slice_pkg::*;
#(
  parameter int PW    = 48,
  parameter int MW    = 36,
  parameter int SHIFT = 17,
  parameter bit PREG  = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_data,
  input  logic          rst_data,
  input  logic [MW-1:0] prod,
  input  logic [PW-1:0] c,
  input  ctrl_t         ctrl,
  input  logic [PW-1:0] pcin,
  output logic [PW-1:0] p
);

  logic [PW-1:0]        p_fb;
  logic [PW-1:0]        prod_ext;
  logic signed [PW-1:0] pcin_s;
  logic signed [PW-1:0] pfb_s;
  logic [PW-1:0]        x_op;
  logic [PW-1:0]        y_op;
  logic [PW-1:0]        z_op;
  logic                 cin_eff;
  logic [PW-1:0]        sum_xy;
  logic [PW-1:0]        result;

  generate
    if (PREG) begin : g_fb
      assign p_fb = p;
    end else begin : g_nofb
      assign p_fb = '0;
    end
  endgenerate

  always_comb begin
    prod_ext = {{(PW-MW){prod[MW-1]}}, prod};
    pcin_s   = pcin;
    pfb_s    = p_fb;

    unique case (ctrl.xsel)
      XS_PROD: x_op = prod_ext;
      XS_PFB:  x_op = p_fb;
      default: x_op = '0;
    endcase

    y_op = (ctrl.ysel == YS_C) ? c : '0;

    unique case (ctrl.zsel)
      ZS_PCIN:    z_op = pcin;
      ZS_PFB:     z_op = p_fb;
      ZS_C:       z_op = c;
      ZS_PCIN_SH: z_op = pcin_s >>> SHIFT;
      ZS_PFB_SH:  z_op = pfb_s >>> SHIFT;
      default:    z_op = '0;
    endcase

    cin_eff = ctrl.rnd ? ~prod[MW-1] : ctrl.cin;
    sum_xy  = x_op + y_op + {{(PW-1){1'b0}}, cin_eff};
    result  = ctrl.sub ? (z_op - sum_xy) : (z_op + sum_xy);
  end

  mac_pipe #(.W(PW), .EN(PREG)) u_preg (
    .clk(clk), .rst_n(rst_n), .srst(rst_data), .ce(ce_data), .d(result), .q(p));

endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_slice_pkg::*;
#(
  parameter int AW    = 18,
  parameter int BW    = 18,
  parameter int PW    = 48,
  parameter int SHIFT = 17,
  parameter bit AREG  = 1'b1,
  parameter bit MREG  = 1'b1,
  parameter bit PREG  = 1'b1,
  localparam int MW   = AW + BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_data,
  input  logic          ce_ctrl,
  input  logic          rst_data,
  input  logic          rst_ctrl,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic [BW-1:0] bcin,
  input  logic          b_sel,
  input  logic [PW-1:0] c,
  input  logic [6:0]    opmode,
  input  logic          sub,
  input  logic          carry_in,
  input  logic          rnd_en,
  input  logic [PW-1:0] pcin,
  output logic [PW-1:0] p,
  output logic [PW-1:0] pcout,
  output logic [BW-1:0] bcout
);

  logic [1:0]    rs_q;
  logic [1:0]    rs_nxt;
  logic          core_rst_n;
  logic [BW-1:0] b_in;
  ctrl_t         ctrl_in;
  logic [MW-1:0] prod_m;
  logic [PW-1:0] c_m;
  ctrl_t         ctrl_m;

  always_comb begin
    rs_nxt = {rs_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_nxt;
  end

  assign core_rst_n = rs_q[1];

  always_comb begin
    b_in         = b_sel ? bcin : b;
    ctrl_in.zsel = z_sel_e'(opmode[6:4]);
    ctrl_in.ysel = y_sel_e'(opmode[3:2]);
    ctrl_in.xsel = x_sel_e'(opmode[1:0]);
    ctrl_in.sub  = sub;
    ctrl_in.cin  = carry_in;
    ctrl_in.rnd  = rnd_en;
  end

  mac_mult #(
    .AW(AW), .BW(BW), .PW(PW), .AREG(AREG), .MREG(MREG)
  ) u_mult (
    .clk(clk), .rst_n(core_rst_n), .ce_data(ce_data), .ce_ctrl(ce_ctrl),
    .rst_data(rst_data), .rst_ctrl(rst_ctrl),
    .a(a), .b(b_in), .c(c), .ctrl(ctrl_in),
    .b_q(bcout), .prod_m(prod_m), .c_m(c_m), .ctrl_m(ctrl_m)
  );

  mac_alu #(
    .PW(PW), .MW(MW), .SHIFT(SHIFT), .PREG(PREG)
  ) u_alu (
    .clk(clk), .rst_n(core_rst_n), .ce_data(ce_data), .rst_data(rst_data),
    .prod(prod_m), .c(c_m), .ctrl(ctrl_m), .pcin(pcin), .p(p)
  );

  assign pcout = p;

endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk #(
  parameter int BW   = 18,
  parameter int PW   = 48,
  parameter bit AREG = 1'b1,
  parameter bit MREG = 1'b1,
  parameter bit PREG = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_data,
  input logic          rst_data,
  input logic          rst_ctrl,
  input logic [BW-1:0] b,
  input logic [BW-1:0] bcin,
  input logic          b_sel,
  input logic [PW-1:0] p,
  input logic [BW-1:0] bcout
);

  generate
    if (PREG) begin : g_preg
      // R10: a synchronous data reset zeroes the registered result
      p_data_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_data |=> (p == '0));

      // R11: with data enable low the registered result is frozen
      p_hold_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_data && !rst_data) |=> $stable(p));

      if (AREG || MREG) begin : g_ctl
        // R12: one cleared control cycle yields a zero result on the next edge
        p_ctrl_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
          ($past(rst_ctrl, 2) && $past(ce_data)) |-> (p == '0));
      end
    end

    if (AREG) begin : g_breg
      // R7: cascade B output is the selected B one edge later
      p_bcout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_data && !rst_data) |=> (bcout == $past(b_sel ? bcin : b)));
    end else begin : g_bwire
      // R7: without an input stage the selected B passes straight through
      always_comb begin
        if (rst_n) begin
          a_bcout_comb_r7: assert (bcout == (b_sel ? bcin : b));
        end
      end
    end
  endgenerate

endmodule

bind mac_slice mac_slice_chk #(
  .BW(BW), .PW(PW), .AREG(AREG), .MREG(MREG), .PREG(PREG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_data(ce_data), .rst_data(rst_data),
  .rst_ctrl(rst_ctrl), .b(b), .bcin(bcin), .b_sel(b_sel), .p(p), .bcout(bcout)
);

// File: tb/tb_mac_slice.sv
module tb_mac_slice;

  typedef struct packed {
    logic [3:0]         req;
    logic signed [17:0] a;
    logic signed [17:0] b;
    logic [47:0]        c;
    logic [6:0]         op;
    logic               sub;
    logic               cin;
    logic               rnd;
    logic [47:0]        res;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{4'd1, 18'sd3,       18'sd5,       48'd0,    7'b000_00_01, 1'b0, 1'b0, 1'b0, 48'd15},              // R1
    '{4'd2, -18'sd3,      18'sd5,       48'd100,  7'b000_01_01, 1'b0, 1'b0, 1'b0, 48'd85},              // R2
    '{4'd1, -18'sd131072, -18'sd131072, 48'd0,    7'b000_00_01, 1'b0, 1'b0, 1'b0, 48'h0004_0000_0000},  // R1
    '{4'd1, 18'sd131071,  -18'sd131072, 48'd0,    7'b000_00_01, 1'b0, 1'b0, 1'b0, 48'hFFFC_0002_0000},  // R1
    '{4'd3, 18'sd7,       18'sd9,       48'd1000, 7'b011_00_01, 1'b1, 1'b0, 1'b0, 48'd937},             // R3
    '{4'd2, 18'sd2,       18'sd2,       48'd10,   7'b011_01_01, 1'b0, 1'b0, 1'b0, 48'd24},              // R2
    '{4'd3, 18'sd0,       18'sd0,       48'd5,    7'b000_01_00, 1'b1, 1'b0, 1'b0, 48'hFFFF_FFFF_FFFB},  // R3
    '{4'd4, 18'sd1,       18'sd1,       48'd0,    7'b000_00_01, 1'b0, 1'b1, 1'b0, 48'd2},               // R4
    '{4'd4, -18'sd3,      18'sd1,       48'd0,    7'b000_01_01, 1'b0, 1'b0, 1'b1, 48'hFFFF_FFFF_FFFD},  // R4
    '{4'd4, 18'sd3,       18'sd1,       48'd0,    7'b000_01_01, 1'b0, 1'b0, 1'b1, 48'd4},               // R4
    '{4'd4, -18'sd3,      18'sd2,       48'd1,    7'b000_01_01, 1'b0, 1'b0, 1'b1, 48'hFFFF_FFFF_FFFB},  // R4
    '{4'd4, 18'sd0,       18'sd5,       48'd1,    7'b000_01_01, 1'b0, 1'b1, 1'b1, 48'd2}                // R4
  };

  logic        clk;
  logic        rst_n;
  logic        ce_data, ce_ctrl, rst_data, rst_ctrl;
  logic [17:0] a, b, bcin;
  logic        b_sel;
  logic [47:0] c, pcin;
  logic [6:0]  opmode;
  logic        sub, carry_in, rnd_en;
  logic [47:0] p_d, pc_d, p_c, pc_c, p_m, pc_m;
  logic [17:0] bc_d, bc_c, bc_m;

  int nchk;
  int nfail;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  mac_slice dut (
    .clk(clk), .rst_n(rst_n), .ce_data(ce_data), .ce_ctrl(ce_ctrl),
    .rst_data(rst_data), .rst_ctrl(rst_ctrl), .a(a), .b(b), .bcin(bcin),
    .b_sel(b_sel), .c(c), .opmode(opmode), .sub(sub), .carry_in(carry_in),
    .rnd_en(rnd_en), .pcin(pcin), .p(p_d), .pcout(pc_d), .bcout(bc_d));

  mac_slice #(.AREG(1'b0), .MREG(1'b0), .PREG(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .ce_data(ce_data), .ce_ctrl(ce_ctrl),
    .rst_data(rst_data), .rst_ctrl(rst_ctrl), .a(a), .b(b), .bcin(bcin),
    .b_sel(b_sel), .c(c), .opmode(opmode), .sub(sub), .carry_in(carry_in),
    .rnd_en(rnd_en), .pcin(pcin), .p(p_c), .pcout(pc_c), .bcout(bc_c));

  mac_slice #(.AREG(1'b1), .MREG(1'b0), .PREG(1'b1)) dut_m (
    .clk(clk), .rst_n(rst_n), .ce_data(ce_data), .ce_ctrl(ce_ctrl),
    .rst_data(rst_data), .rst_ctrl(rst_ctrl), .a(a), .b(b), .bcin(bcin),
    .b_sel(b_sel), .c(c), .opmode(opmode), .sub(sub), .carry_in(carry_in),
    .rnd_en(rnd_en), .pcin(pcin), .p(p_m), .pcout(pc_m), .bcout(bc_m));

  task automatic check(input string tag, input logic [47:0] got, input logic [47:0] want);
    nchk++;
    if (got !== want) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input vec_t v);
    a        = v.a;
    b        = v.b;
    c        = v.c;
    opmode   = v.op;
    sub      = v.sub;
    carry_in = v.cin;
    rnd_en   = v.rnd;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    nchk = 0; nfail = 0;
    rst_n = 1'b0; ce_data = 1'b1; ce_ctrl = 1'b1; rst_data = 1'b0; rst_ctrl = 1'b0;
    a = '0; b = '0; bcin = '0; b_sel = 1'b0; c = '0; pcin = '0;
    opmode = '0; sub = 1'b0; carry_in = 1'b0; rnd_en = 1'b0;

    // R13: asynchronous reset clears the result and the B cascade
    settle(3);
    check("R13 p in reset", p_d, 48'd0);
    check("R13 bcout in reset", {30'd0, bc_d}, 48'd0);
    rst_n = 1'b1;
    settle(4);

    // R9: stream the table through three pipeline depths
    for (int i = 0; i < NV + 3; i++) begin
      if (i >= 3) check($sformatf("R9 R%0d latency3 row %0d", TBL[i-3].req, i-3), p_d, TBL[i-3].res);
      if (i >= 2 && i - 2 < NV)
        check($sformatf("R9 R%0d latency2 row %0d", TBL[i-2].req, i-2), p_m, TBL[i-2].res);
      if (i < NV) begin
        drive(TBL[i]);
        #1;
        check($sformatf("R9 R%0d latency0 row %0d", TBL[i].req, i), p_c, TBL[i].res);
      end
      @(negedge clk);
    end

    // R5: accumulate product 6 per cycle from a cleared slice
    a = 18'sd2; b = 18'sd3; c = '0; opmode = 7'b010_00_01;
    sub = 1'b0; carry_in = 1'b0; rnd_en = 1'b0;
    rst_data = 1'b1; rst_ctrl = 1'b1;
    settle(1);
    rst_data = 1'b0; rst_ctrl = 1'b0;
    settle(5);
    check("R5 accumulate", p_d, 48'd18);
    check("R5 no feedback without PREG", p_c, 48'd6);

    // R11: data enable low freezes the result
    ce_data = 1'b0;
    settle(3);
    check("R11 hold", p_d, 48'd18);

    // R10: data reset wins over a low enable
    rst_data = 1'b1;
    settle(1);
    check("R10 reset over ce", p_d, 48'd0);
    rst_data = 1'b0; ce_data = 1'b1;

    // R12: control enable low keeps the old mode
    a = 18'sd3; b = 18'sd5; c = 48'd77; opmode = 7'b000_00_01;
    settle(5);
    check("R12 base mode", p_d, 48'd15);
    ce_ctrl = 1'b0; opmode = 7'b011_00_00;
    settle(5);
    check("R12 mode held", p_d, 48'd15);
    ce_ctrl = 1'b1;
    settle(5);
    check("R12 mode applied", p_d, 48'd77);
    rst_ctrl = 1'b1;
    settle(3);
    check("R12 control reset", p_d, 48'd0);
    rst_ctrl = 1'b0;

    // R6: cascade P input, plain and shifted
    a = 18'sd2; b = 18'sd3; c = '0; opmode = 7'b001_00_01; pcin = 48'd1000;
    settle(5);
    check("R6 cascade add", p_d, 48'd1006);
    check("R8 pcout follows p", pc_d, 48'd1006);
    opmode = 7'b100_00_01; pcin = 48'hFFFF_FFF0_0000;
    settle(5);
    check("R6 negative shift", p_d, 48'hFFFF_FFFF_FFFE);
    opmode = 7'b100_00_00; pcin = 48'h0000_0006_0000;
    settle(5);
    check("R6 positive shift", p_d, 48'd3);

    // R6: shifted feedback converges to 2^18 + 2
    pcin = '0; c = 48'h0000_0004_0000; opmode = 7'b101_01_00;
    rst_data = 1'b1;
    settle(1);
    rst_data = 1'b0;
    settle(8);
    check("R6 feedback shift", p_d, 48'h0000_0004_0002);

    // R7: B taken from the cascade input
    a = 18'sd2; b = 18'd0; bcin = 18'd55; b_sel = 1'b1; c = '0; opmode = 7'b000_00_01;
    settle(5);
    check("R7 product via bcin", p_d, 48'd110);
    check("R7 bcout registered", {30'd0, bc_d}, 48'd55);
    check("R7 bcout direct", {30'd0, bc_c}, 48'd55);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule